// File: doc/BRIEF.md
# Translation Control and Table Base Register File

This block is the software-visible register file of an I/O address translation unit. It holds two 64-bit registers: a control word, whose low bit switches translation on, and the physical base address of the translation table. Both values are driven out continuously so that the translation engine can read them without a bus access.

Software reaches the registers through a simple slave port with a byte offset, separate read and write strobes, 64-bit write data and an access size of either four or eight bytes. An 8-byte access at a register's aligned offset moves the whole word. A 4-byte access moves one 32-bit half in big-endian order: the aligned offset selects the upper half and offset +4 selects the lower half. A 4-byte write merges into the register and leaves the other half as it was. The slot after the two registers is a cache-flush placeholder. Writes to it are accepted and have no effect, and reads of it return zero. Every other offset is unmapped.

Read data is registered. It appears on the clock edge that samples the read strobe and holds until the next read.

Top module: `iommu_cfg_regs`

## Requirements
- R1: While reset is asserted, and after it is released, the control word, the table base and the read data are all zero. Translation is therefore disabled.
- R2: An 8-byte write at offset 0x00 (control) or 0x08 (table base) replaces all 64 bits of that register with the write data.
- R3: A 4-byte write at offset 0x00 or 0x08 loads write data bits 31:0 into register bits 63:32 and leaves bits 31:0 unchanged.
- R4: A 4-byte write at offset 0x04 or 0x0C loads write data bits 31:0 into register bits 31:0 and leaves bits 63:32 unchanged.
- R5: An 8-byte read at 0x00 or 0x08 returns the whole register. A 4-byte read at the aligned offset returns register bits 63:32 on read data bits 31:0. A 4-byte read at +4 returns register bits 31:0 on read data bits 31:0. For 4-byte reads, read data bits 63:32 are zero.
- R6: Read data changes only on the clock edge that samples the read strobe, and holds between reads. A read and a write in the same cycle return the value the register had before the write.
- R7: Writes to the flush offsets 0x10 and 0x14, of either size, leave both registers unchanged. Reads of the flush offsets return zero.
- R8: Any other offset is unmapped, and so is an 8-byte access at 0x04 or 0x0C. Reads of an unmapped offset return zero, and writes to one change neither register.
- R9: The control word and table base outputs show the register contents at all times and change on the same edge that performs the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busSize8 | input | 1 | 1 for an 8-byte access, 0 for a 4-byte access |
| busWdata | input | 64 | Write data; a 4-byte write uses bits 31:0 |
| busRdata | output | 64 | Registered read data |
| ctrlWord | output | 64 | Current control register |
| tableBase | output | 64 | Current table base register |

## Verification
The bench targets the half-word merges. It writes one half and then reads both halves back. A design that swapped the big-endian placement, or cleared the untouched half, shows the wrong word on the exported outputs. The 8-byte access at offset +4 gets its own stimulus: a decoder that only looks at the offset would wrongly treat it as a lower-half write. Flush and unmapped writes use data that differs from every stored value, so a write that leaks through is visible. A read and a write are also issued in the same cycle to confirm that the read returns the value from before the write.

// File: rtl/iommu_regs_pkg.sv
package iommu_regs_pkg;
  localparam int REG_W     = 64;
  localparam int HALF_W    = REG_W / 2;
  localparam int NUM_REGS  = 2;  // 0: control word, 1: table base
  localparam int REG_IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  typedef enum logic [1:0] {
    RD_ZERO  = 2'd0,
    RD_FULL  = 2'd1,
    RD_UPPER = 2'd2,
    RD_LOWER = 2'd3
  } rdShape_e;

  // strobes from the decoder to the register datapath
  typedef struct packed {
    logic [NUM_REGS-1:0]  wrUpper;
    logic [NUM_REGS-1:0]  wrLower;
    logic                 upperFromHigh;  // 8-byte write: upper half takes wdata[63:32]
    logic                 rdLoad;
    rdShape_e             rdShape;
    logic [REG_IDX_W-1:0] rdIdx;
  } regStrobe_t;
endpackage

// File: rtl/iommu_cfg_decode.sv
module iommu_cfg_decode
  import iommu_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic              busSize8,
  output regStrobe_t        strobe
);
  localparam int SLOT_W = ADDR_W - 3;

  logic [SLOT_W-1:0] slot;
  logic [2:0]        sub;
  logic              isAligned;
  logic              isPlus4;
  logic              regSpace;
  logic [NUM_REGS-1:0] slotHit;

  assign slot      = busAddr[ADDR_W-1:3];
  assign sub       = busAddr[2:0];
  assign isAligned = (sub == 3'd0);
  assign isPlus4   = (sub == 3'd4);
  assign regSpace  = (slot < SLOT_W'(NUM_REGS));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    assign slotHit[i] = (slot == SLOT_W'(i));
    // upper half: any size at the aligned offset
    assign strobe.wrUpper[i] = busWe && slotHit[i] && isAligned;
    // lower half: 8-byte aligned, or 4-byte at +4
    assign strobe.wrLower[i] = busWe && slotHit[i] &&
                               ((isAligned && busSize8) || (isPlus4 && !busSize8));
  end

  assign strobe.upperFromHigh = busSize8;
  assign strobe.rdLoad        = busRe;
  assign strobe.rdIdx         = slot[REG_IDX_W-1:0];

  always_comb begin
    strobe.rdShape = RD_ZERO;
    if (regSpace) begin
      if (isAligned && busSize8)       strobe.rdShape = RD_FULL;
      else if (isAligned && !busSize8) strobe.rdShape = RD_UPPER;
      else if (isPlus4 && !busSize8)   strobe.rdShape = RD_LOWER;
      else                             strobe.rdShape = RD_ZERO;
    end
  end
endmodule

// File: rtl/iommu_cfg_datapath.sv
module iommu_cfg_datapath
  import iommu_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strobe,
  input  logic [REG_W-1:0] busWdata,
  output logic [REG_W-1:0] busRdata,
  output logic [REG_W-1:0] regOut [NUM_REGS]
);
  logic [HALF_W-1:0] upperQ [NUM_REGS];
  logic [HALF_W-1:0] lowerQ [NUM_REGS];
  logic [HALF_W-1:0] upperIn;

  assign upperIn = strobe.upperFromHigh ? busWdata[REG_W-1:HALF_W] : busWdata[HALF_W-1:0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        upperQ[i] <= '0;
        lowerQ[i] <= '0;
      end else begin
        if (strobe.wrUpper[i]) upperQ[i] <= upperIn;
        if (strobe.wrLower[i]) lowerQ[i] <= busWdata[HALF_W-1:0];
      end
    end
    assign regOut[i] = {upperQ[i], lowerQ[i]};

    // R3
    lower_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrUpper[i] && !strobe.wrLower[i]) |=> $stable(lowerQ[i]));
    // R4
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrLower[i] && !strobe.wrUpper[i]) |=> $stable(upperQ[i]));
    // R2
    full_write_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrUpper[i] && strobe.wrLower[i]) |=> (regOut[i] == $past(busWdata)));
  end

  logic [REG_W-1:0] selReg;
  logic [REG_W-1:0] rdNext;
  assign selReg = regOut[strobe.rdIdx];

  always_comb begin
    unique case (strobe.rdShape)
      RD_FULL:  rdNext = selReg;
      RD_UPPER: rdNext = {{HALF_W{1'b0}}, selReg[REG_W-1:HALF_W]};
      RD_LOWER: rdNext = {{HALF_W{1'b0}}, selReg[HALF_W-1:0]};
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)              busRdata <= '0;
    else if (strobe.rdLoad) busRdata <= rdNext;
  end

  // R6
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdLoad |=> $stable(busRdata));
endmodule

// File: rtl/iommu_cfg_regs.sv
module iommu_cfg_regs
  import iommu_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic              busSize8,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  output logic [REG_W-1:0]  ctrlWord,
  output logic [REG_W-1:0]  tableBase
);
  regStrobe_t       strobe;
  logic [REG_W-1:0] regOut [NUM_REGS];

  iommu_cfg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .busAddr (busAddr),
    .busWe   (busWe),
    .busRe   (busRe),
    .busSize8(busSize8),
    .strobe  (strobe)
  );

  iommu_cfg_datapath u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .regOut  (regOut)
  );

  assign ctrlWord  = regOut[0];
  assign tableBase = regOut[1];

  logic flushAddr;
  assign flushAddr = (busAddr[ADDR_W-1:3] == (ADDR_W-3)'(NUM_REGS));

  // R7
  flush_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && flushAddr) |=> ($stable(ctrlWord) && $stable(tableBase)));
  // R7
  flush_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && flushAddr) |=> (busRdata == '0));
  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |=> ($stable(ctrlWord) && $stable(tableBase)));
endmodule

// File: tb/iommu_cfg_regs_tb.sv
module iommu_cfg_regs_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic        busSize8 = 1'b0;
  logic [63:0] busWdata = '0;
  logic [63:0] busRdata, ctrlWord, tableBase;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  // reference model state
  logic [63:0] mCtrl = '0, mBase = '0, mRd = '0;

  always #10 clk = ~clk;  // 50 MHz

  iommu_cfg_regs u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busSize8(busSize8), .busWdata(busWdata), .busRdata(busRdata),
    .ctrlWord(ctrlWord), .tableBase(tableBase)
  );

  function automatic logic [63:0] modelRead(input logic [7:0] a, input logic s8,
                                            input logic [63:0] c, input logic [63:0] b);
    logic [63:0] r;
    r = (a < 8'h08) ? c : b;
    if (a == 8'h00 || a == 8'h08) return s8 ? r : {32'h0, r[63:32]};
    if ((a == 8'h04 || a == 8'h0C) && !s8) return {32'h0, r[31:0]};
    return 64'h0;
  endfunction

  function automatic logic [63:0] modelWrite(input logic [63:0] old, input logic [2:0] sub,
                                             input logic s8, input logic [63:0] d);
    if (sub == 3'd0 && s8)  return d;
    if (sub == 3'd0 && !s8) return {d[31:0], old[31:0]};
    if (sub == 3'd4 && !s8) return {old[63:32], d[31:0]};
    return old;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl <= '0; mBase <= '0; mRd <= '0;
    end else begin
      if (busRe) mRd <= modelRead(busAddr, busSize8, mCtrl, mBase);
      if (busWe && busAddr[7:3] == 5'd0) mCtrl <= modelWrite(mCtrl, busAddr[2:0], busSize8, busWdata);
      if (busWe && busAddr[7:3] == 5'd1) mBase <= modelWrite(mBase, busAddr[2:0], busSize8, busWdata);
    end
  end

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    check(curReq, "rdata", busRdata, mRd);
    check(curReq, "ctrlWord", ctrlWord, mCtrl);
    check(curReq, "tableBase", tableBase, mBase);
  end

  task automatic op(input logic we, input logic re, input logic [7:0] a,
                    input logic s8, input logic [63:0] d);
    @(negedge clk);
    busWe = we; busRe = re; busAddr = a; busSize8 = s8; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busRe = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    curReq = "R1";
    repeat (3) @(negedge clk);
    check("R1", "reset ctrl", ctrlWord, 64'h0);
    check("R1", "reset rdata", busRdata, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "post-reset base", tableBase, 64'h0);

    curReq = "R2";
    op(1, 0, 8'h00, 1, 64'h1122334455667788);
    check("R2", "ctrl full", ctrlWord, 64'h1122334455667788);
    op(1, 0, 8'h08, 1, 64'hA5A5A5A5_5A5A5A5A);
    check("R2", "base full", tableBase, 64'hA5A5A5A5_5A5A5A5A);

    curReq = "R3";
    op(1, 0, 8'h00, 0, 64'hFFFF0000_DEADBEEF);
    check("R3", "ctrl upper", ctrlWord, 64'hDEADBEEF_55667788);
    op(1, 0, 8'h08, 0, 64'h0000_0000_01234567);
    check("R3", "base upper", tableBase, 64'h01234567_5A5A5A5A);

    curReq = "R4";
    op(1, 0, 8'h0C, 0, 64'h77777777_0BADF00D);
    check("R4", "base lower", tableBase, 64'h01234567_0BADF00D);
    op(1, 0, 8'h04, 0, 64'h0000_0000_CAFEF00D);
    check("R4", "ctrl lower", ctrlWord, 64'hDEADBEEF_CAFEF00D);

    curReq = "R5";
    op(0, 1, 8'h00, 1, '0);
    check("R5", "ctrl 8B read", busRdata, 64'hDEADBEEF_CAFEF00D);
    op(0, 1, 8'h00, 0, '0);
    check("R5", "ctrl upper read", busRdata, 64'h00000000_DEADBEEF);
    op(0, 1, 8'h04, 0, '0);
    check("R5", "ctrl lower read", busRdata, 64'h00000000_CAFEF00D);
    op(0, 1, 8'h08, 1, '0);
    check("R5", "base 8B read", busRdata, 64'h01234567_0BADF00D);
    op(0, 1, 8'h0C, 0, '0);
    check("R5", "base lower read", busRdata, 64'h00000000_0BADF00D);

    curReq = "R6";
    op(0, 1, 8'h08, 0, '0);
    repeat (3) @(negedge clk);
    check("R6", "rdata held", busRdata, 64'h00000000_01234567);
    op(1, 1, 8'h00, 1, 64'h0F0F0F0F_F0F0F0F0);
    check("R6", "read-before-write", busRdata, 64'hDEADBEEF_CAFEF00D);
    check("R6", "write same cycle", ctrlWord, 64'h0F0F0F0F_F0F0F0F0);

    curReq = "R7";
    op(1, 0, 8'h10, 1, 64'hFFFFFFFF_FFFFFFFF);
    op(1, 0, 8'h14, 0, 64'hFFFFFFFF_FFFFFFFF);
    op(1, 0, 8'h10, 0, 64'hFFFFFFFF_FFFFFFFF);
    check("R7", "ctrl after flush", ctrlWord, 64'h0F0F0F0F_F0F0F0F0);
    check("R7", "base after flush", tableBase, 64'h01234567_0BADF00D);
    op(0, 1, 8'h10, 1, '0);
    check("R7", "flush read", busRdata, 64'h0);
    op(0, 1, 8'h00, 1, '0);
    op(0, 1, 8'h14, 0, '0);
    check("R7", "flush+4 read", busRdata, 64'h0);

    curReq = "R8";
    op(1, 0, 8'h04, 1, 64'h13579BDF_2468ACE0);
    check("R8", "8B at ctrl+4", ctrlWord, 64'h0F0F0F0F_F0F0F0F0);
    op(1, 0, 8'h0C, 1, 64'h13579BDF_2468ACE0);
    check("R8", "8B at base+4", tableBase, 64'h01234567_0BADF00D);
    op(1, 0, 8'h01, 1, 64'h13579BDF_2468ACE0);
    op(1, 0, 8'h0A, 0, 64'h13579BDF_2468ACE0);
    op(1, 0, 8'h18, 1, 64'h13579BDF_2468ACE0);
    op(1, 0, 8'hF8, 1, 64'h13579BDF_2468ACE0);
    check("R8", "ctrl after unmapped", ctrlWord, 64'h0F0F0F0F_F0F0F0F0);
    check("R8", "base after unmapped", tableBase, 64'h01234567_0BADF00D);
    op(0, 1, 8'h08, 1, '0);
    op(0, 1, 8'h04, 1, '0);
    check("R8", "8B read at +4", busRdata, 64'h0);
    op(0, 1, 8'h00, 1, '0);
    op(0, 1, 8'h20, 1, '0);
    check("R8", "unmapped read", busRdata, 64'h0);

    curReq = "R9";
    for (int k = 0; k < 8; k++) begin
      op(1, 0, (k % 2 == 0) ? 8'h00 : 8'h0C, k[1], {32'h100 + k, 32'h900 + k});
    end
    check("R9", "final base", tableBase, mBase);
    check("R9", "final ctrl", ctrlWord, mCtrl);

    curReq = "R1";
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check("R1", "re-reset ctrl", ctrlWord, 64'h0);
    check("R1", "re-reset base", tableBase, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule